// File: doc/BRIEF.md
# Paced Memory/I-O Byte DMA Channel

This block is a single DMA channel that copies bytes between a 20-bit memory space and a 16-bit I/O space. Software loads a memory address, a fixed I/O address, a byte count and a mode byte, then sets the channel enable through a status register. The enable can only change in a write whose write-protect bit is clear. A request line, normally driven by an on-chip serial port, paces the channel. In edge mode each rising edge moves exactly one byte. In level mode the channel keeps moving bytes for as long as the line stays high.

Each accepted request produces one read cycle on the source bus and then one write cycle on the destination bus. The memory address steps up or down by one, modulo 2^20. The I/O address stays fixed and the count drops by one. When the count runs out, the channel disables itself, sets a sticky done flag and, if enabled, raises an interrupt. A loaded count of zero means 65536 bytes.

For a transmit stream, software writes the first byte to the serial port itself, so the port starts full and its first request asks for the second byte. For a receive stream, the port starts empty and each received byte raises one request.

Top module: `io_dma_channel`

## Requirements
- R1: After reset all channel registers read zero, `irq` is low and no bus strobe (`memRd`, `memWr`, `ioRd`, `ioWr`) is asserted.
- R2: Registers at `regAddr` offsets are readable and writable: 0..2 hold the memory address, low byte first, with offset 2 bits 3:0 holding address bits 19:16 and bits 7:4 reading 0. Offsets 3..4 hold the I/O address, low byte first. Offsets 5..6 hold the count, low byte first. Offset 7 is the mode byte: bit0 direction (0 memory to I/O, 1 I/O to memory), bit1 memory decrement, bit2 edge sensing; the other bits read 0. Offset 8 is the status byte: bit0 enable, bit1 enable write-protect (write only, reads 0), bit2 interrupt enable, bit3 done.
- R3: A status write changes the enable bit to `regWrData[0]` only when `regWrData[1]` is 0 in that write; otherwise enable keeps its value. The interrupt enable is written on every status write.
- R4: An accepted request gives exactly one source read cycle and, on the next clock cycle, one destination write cycle carrying the byte just read. In memory-to-I/O mode these are `memRd` at the memory address and then `ioWr` at the I/O address. In I/O-to-memory mode they are `ioRd` and then `memWr`.
- R5: After each byte the memory address moves by +1 (or by -1 in decrement mode), the I/O address is unchanged and the count drops by one.
- R6: When a byte brings the count to zero, enable clears and done sets. `irq` equals done AND interrupt enable. Writing status with bit3 = 1 clears done, and with it `irq`.
- R7: A loaded count of 0 stands for 65536 bytes: after one byte the count reads 0xFFFF and enable stays set.
- R8: In edge mode one rising edge of `dmaReq` moves exactly one byte, however long the line stays high. In level mode a new byte starts every third cycle while `dmaReq` is high.
- R9: In edge mode a rising edge that arrives during a transfer is held pending and starts one more transfer right after the current one.
- R10: The memory address wraps modulo 2^20: incrementing 0xFFFFF gives 0x00000, and decrementing 0x00000 gives 0xFFFFF.
- R11: Requests that arrive while the channel is disabled start no transfer and leave nothing pending for a later enable.
- R12: When a termination and a status write with bit3 = 1 fall in the same cycle, done ends set and `irq` stays high if it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational from `regAddr`) |
| dmaReq | input | 1 | Transfer request from the serial port |
| memAddr | output | 20 | Current memory address |
| memRd | output | 1 | Memory read cycle |
| memWr | output | 1 | Memory write cycle |
| memRdData | input | 8 | Memory read data, valid during `memRd` |
| memWrData | output | 8 | Memory write data |
| ioAddr | output | 16 | I/O address |
| ioRd | output | 1 | I/O read cycle |
| ioWr | output | 1 | I/O write cycle |
| ioRdData | input | 8 | I/O read data, valid during `ioRd` |
| ioWrData | output | 8 | I/O write data |
| irq | output | 1 | Termination interrupt |

## Verification
Two functions can fall in the same cycle. The terminating byte's write cycle sets done, and a software status write can clear done with bit3 in that same clock. The bench provokes this by launching a one-byte transfer and timing a status write with bit3 set to land exactly on the write-cycle edge. It then judges the result by reading back status 0x0C with `irq` high, because the set must win. A second overlap, a fresh request edge during a running transfer, is provoked by raising `dmaReq` in the write cycle. It is judged by the extra read strobe three cycles later and by a count that drops by exactly two.

// File: rtl/io_dma_pkg.sv
package io_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } dmaState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic readCycle;   // source read, capture data at end of cycle
    logic writeCycle;  // destination write, update address/count at end
  } dmaStrobes_t;

endpackage

// File: rtl/io_dma_datapath.sv
module io_dma_datapath
  import io_dma_pkg::*;
#(
  parameter int MEM_AW = 20,
  parameter int IO_AW  = 16,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  dmaStrobes_t       strobes,
  output logic              chanEnable,
  output logic              edgeMode,
  output logic [MEM_AW-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  input  logic [7:0]        memRdData,
  output logic [7:0]        memWrData,
  output logic [IO_AW-1:0]  ioAddr,
  output logic              ioRd,
  output logic              ioWr,
  input  logic [7:0]        ioRdData,
  output logic [7:0]        ioWrData,
  output logic              irq
);

  localparam int MEM_BYTES = (MEM_AW + 7) / 8;
  localparam int IO_BYTES  = (IO_AW + 7) / 8;
  localparam int CNT_BYTES = (CNT_W + 7) / 8;
  localparam int MEM_BASE  = 0;
  localparam int IO_BASE   = MEM_BASE + MEM_BYTES;
  localparam int CNT_BASE  = IO_BASE + IO_BYTES;
  localparam int MODE_OFF  = CNT_BASE + CNT_BYTES;
  localparam int STAT_OFF  = MODE_OFF + 1;

  logic [MEM_AW-1:0] memAddrQ, memAddrD;
  logic [IO_AW-1:0]  ioAddrQ, ioAddrD;
  logic [CNT_W-1:0]  cntQ, cntD;
  logic              dirIoToMem, decMode, edgeQ;
  logic              enableQ, enableD, irqEnQ, irqEnD, doneQ, doneD;
  logic [7:0]        dataQ;
  logic              wrStat, wrMode, termHit, cntWritten;

  assign wrStat  = regWrEn && (regAddr == REG_AW'(STAT_OFF));
  assign wrMode  = regWrEn && (regAddr == REG_AW'(MODE_OFF));
  assign termHit = strobes.writeCycle && (cntQ == CNT_W'(1));

  // Next-state of address and count: hardware step, then software bytes win
  always_comb begin
    memAddrD = memAddrQ;
    ioAddrD  = ioAddrQ;
    cntD     = cntQ;
    cntWritten = 1'b0;
    if (strobes.writeCycle) begin
      memAddrD = decMode ? (memAddrQ - MEM_AW'(1)) : (memAddrQ + MEM_AW'(1));
      cntD     = cntQ - CNT_W'(1);
    end
    for (int i = 0; i < MEM_AW; i++)
      if (regWrEn && regAddr == REG_AW'(MEM_BASE + i / 8))
        memAddrD[i] = regWrData[i % 8];
    for (int i = 0; i < IO_AW; i++)
      if (regWrEn && regAddr == REG_AW'(IO_BASE + i / 8))
        ioAddrD[i] = regWrData[i % 8];
    for (int i = 0; i < CNT_W; i++)
      if (regWrEn && regAddr == REG_AW'(CNT_BASE + i / 8)) begin
        cntD[i]    = regWrData[i % 8];
        cntWritten = 1'b1;
      end
  end

  // Status next-state: termination wins over software
  always_comb begin
    enableD = enableQ;
    irqEnD  = irqEnQ;
    doneD   = doneQ;
    if (wrStat) begin
      if (!regWrData[1]) enableD = regWrData[0];
      irqEnD = regWrData[2];
      if (regWrData[3]) doneD = 1'b0;
    end
    if (termHit) begin
      enableD = 1'b0;
      doneD   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddrQ   <= '0;
      ioAddrQ    <= '0;
      cntQ       <= '0;
      dirIoToMem <= 1'b0;
      decMode    <= 1'b0;
      edgeQ      <= 1'b0;
      enableQ    <= 1'b0;
      irqEnQ     <= 1'b0;
      doneQ      <= 1'b0;
      dataQ      <= '0;
    end else begin
      memAddrQ <= memAddrD;
      ioAddrQ  <= ioAddrD;
      cntQ     <= cntD;
      enableQ  <= enableD;
      irqEnQ   <= irqEnD;
      doneQ    <= doneD;
      if (wrMode) begin
        dirIoToMem <= regWrData[0];
        decMode    <= regWrData[1];
        edgeQ      <= regWrData[2];
      end
      if (strobes.readCycle)
        dataQ <= dirIoToMem ? ioRdData : memRdData;
    end
  end

  // Register readback
  always_comb begin
    regRdData = '0;
    for (int i = 0; i < MEM_AW; i++)
      if (regAddr == REG_AW'(MEM_BASE + i / 8)) regRdData[i % 8] = memAddrQ[i];
    for (int i = 0; i < IO_AW; i++)
      if (regAddr == REG_AW'(IO_BASE + i / 8)) regRdData[i % 8] = ioAddrQ[i];
    for (int i = 0; i < CNT_W; i++)
      if (regAddr == REG_AW'(CNT_BASE + i / 8)) regRdData[i % 8] = cntQ[i];
    if (regAddr == REG_AW'(MODE_OFF))
      regRdData = {5'b0, edgeQ, decMode, dirIoToMem};
    if (regAddr == REG_AW'(STAT_OFF))
      regRdData = {4'b0, doneQ, irqEnQ, 1'b0, enableQ};
  end

  assign chanEnable = enableQ;
  assign edgeMode   = edgeQ;
  assign memAddr    = memAddrQ;
  assign ioAddr     = ioAddrQ;
  assign memRd      = strobes.readCycle  && !dirIoToMem;
  assign ioRd       = strobes.readCycle  &&  dirIoToMem;
  assign memWr      = strobes.writeCycle &&  dirIoToMem;
  assign ioWr       = strobes.writeCycle && !dirIoToMem;
  assign memWrData  = dataQ;
  assign ioWrData   = dataQ;
  assign irq        = doneQ && irqEnQ;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWr, ioRd, ioWr})); // R4
  AST_SRC_THEN_DST: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || ioRd) |=> (memWr || ioWr)); // R4
  AST_IO_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeCycle && !regWrEn) |=> $stable(ioAddrQ)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeCycle && !cntWritten) |=> (cntQ == $past(cntQ) - CNT_W'(1))); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(strobes.writeCycle)); // R6
  AST_ENABLE_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enableQ) |-> $past(regWrEn && !regWrData[1])); // R3

endmodule

// File: rtl/io_dma_control.sv
module io_dma_control
  import io_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dmaReq,
  input  logic        chanEnable,
  input  logic        edgeMode,
  output dmaStrobes_t strobes
);

  dmaState_t stateQ, stateD;
  logic      prevReq, pendingQ, pendingD;
  logic      edgeSeen, reqLive, startNow;

  assign edgeSeen = dmaReq && !prevReq;
  assign reqLive  = edgeMode ? (pendingQ || edgeSeen) : dmaReq;
  assign startNow = (stateQ == ST_IDLE) && chanEnable && reqLive;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (startNow) stateD = ST_READ;
      ST_READ:  stateD = ST_WRITE;
      ST_WRITE: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
    // One pending edge at most; a start consumes one
    pendingD = chanEnable && edgeMode &&
               (startNow ? (pendingQ && edgeSeen) : (pendingQ || edgeSeen));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      prevReq  <= 1'b0;
      pendingQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      prevReq  <= dmaReq;
      pendingQ <= pendingD;
    end
  end

  assign strobes.readCycle  = (stateQ == ST_READ);
  assign strobes.writeCycle = (stateQ == ST_WRITE);

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEnable && stateQ == ST_IDLE) |=> (stateQ == ST_IDLE)); // R11
  AST_LEVEL_NO_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    !edgeMode |=> !pendingQ); // R8

endmodule

// File: rtl/io_dma_channel.sv
module io_dma_channel
  import io_dma_pkg::*;
#(
  parameter int MEM_AW = 20,
  parameter int IO_AW  = 16,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              dmaReq,
  output logic [MEM_AW-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  input  logic [7:0]        memRdData,
  output logic [7:0]        memWrData,
  output logic [IO_AW-1:0]  ioAddr,
  output logic              ioRd,
  output logic              ioWr,
  input  logic [7:0]        ioRdData,
  output logic [7:0]        ioWrData,
  output logic              irq
);

  dmaStrobes_t strobes;
  logic        chanEnable, edgeMode;

  io_dma_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dmaReq     (dmaReq),
    .chanEnable (chanEnable),
    .edgeMode   (edgeMode),
    .strobes    (strobes)
  );

  io_dma_datapath #(
    .MEM_AW (MEM_AW),
    .IO_AW  (IO_AW),
    .CNT_W  (CNT_W),
    .REG_AW (REG_AW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .strobes    (strobes),
    .chanEnable (chanEnable),
    .edgeMode   (edgeMode),
    .memAddr    (memAddr),
    .memRd      (memRd),
    .memWr      (memWr),
    .memRdData  (memRdData),
    .memWrData  (memWrData),
    .ioAddr     (ioAddr),
    .ioRd       (ioRd),
    .ioWr       (ioWr),
    .ioRdData   (ioRdData),
    .ioWrData   (ioWrData),
    .irq        (irq)
  );

endmodule

// File: tb/io_dma_channel_test.sv
`timescale 1ns/1ps
module io_dma_channel_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        dmaReq = 1'b0;
  logic [19:0] memAddr;
  logic        memRd, memWr, ioRd, ioWr, irq;
  logic [7:0]  memRdData, memWrData, ioWrData;
  logic [7:0]  ioRdData = '0;
  logic [15:0] ioAddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [7:0] memModel(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h9};
  endfunction

  assign memRdData = memModel(memAddr);

  io_dma_channel uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dmaReq(dmaReq),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memRdData(memRdData),
    .memWrData(memWrData), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioRdData(ioRdData), .ioWrData(ioWrData), .irq(irq)
  );

  // {dir, dec, memStart, ioAddr, count}
  localparam logic [45:0] VECS [4] = '{
    {1'b0, 1'b0, 20'h12345, 16'h00A0, 8'd3},
    {1'b1, 1'b0, 20'h40000, 16'h00B1, 8'd2},
    {1'b0, 1'b1, 20'h00001, 16'h0102, 8'd3},
    {1'b1, 1'b0, 20'hFFFFE, 16'h0200, 8'd3}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1'b1;
    $finish;
  endtask

  // all tasks enter and leave at a falling edge
  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic readCount(output logic [15:0] c);
    logic [7:0] lo, hi;
    readReg(4'd5, lo);
    readReg(4'd6, hi);
    c = {hi, lo};
  endtask

  task automatic setupChan(input logic dir, input logic dec, input logic edgeBit,
                           input logic [19:0] m, input logic [15:0] io,
                           input logic [15:0] cnt);
    writeReg(4'd8, 8'h08);  // disable, clear done
    writeReg(4'd0, m[7:0]);
    writeReg(4'd1, m[15:8]);
    writeReg(4'd2, {4'h0, m[19:16]});
    writeReg(4'd3, io[7:0]);
    writeReg(4'd4, io[15:8]);
    writeReg(4'd5, cnt[7:0]);
    writeReg(4'd6, cnt[15:8]);
    writeReg(4'd7, {5'b0, edgeBit, dec, dir});
    writeReg(4'd8, 8'h05);  // enable + irq enable, wp = 0
  endtask

  task automatic runByte(input logic dir, input logic [19:0] expMem,
                         input logic [15:0] expIo, input logic [7:0] expData);
    dmaReq = 1'b1;
    @(negedge clk);
    dmaReq = 1'b0;
    if (!dir)
      check(memRd && !ioRd && !memWr && !ioWr && memAddr == expMem,
            "R4 mem read cycle", {memRd, ioRd, memAddr}, {2'b10, expMem});
    else
      check(ioRd && !memRd && !memWr && !ioWr && ioAddr == expIo,
            "R4 io read cycle", {ioRd, memRd, ioAddr}, {2'b10, expIo});
    @(negedge clk);
    if (!dir)
      check(ioWr && !memWr && ioAddr == expIo && ioWrData == expData,
            "R4 io write cycle", {ioWr, ioAddr, ioWrData}, {1'b1, expIo, expData});
    else
      check(memWr && !ioWr && memAddr == expMem && memWrData == expData,
            "R4 mem write cycle", {memWr, memAddr, memWrData}, {1'b1, expMem, expData});
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finishRun();
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [15:0] cnt;
    logic [19:0] expMem;
    logic [7:0]  expData;

    repeat (3) @(negedge clk);
    // R1 reset state
    begin
      logic bad = 1'b0;
      for (int a = 0; a <= 8; a++) begin
        readReg(4'(a), rd);
        if (rd != 8'h00) bad = 1'b1;
      end
      check(!bad && !irq && !memRd && !memWr && !ioRd && !ioWr,
            "R1 reset values", {bad, irq, memRd, memWr, ioRd, ioWr}, 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2 readback
    writeReg(4'd2, 8'hF7);
    readReg(4'd2, rd);
    check(rd == 8'h07, "R2 mem addr high byte", rd, 8'h07);
    writeReg(4'd4, 8'hA5);
    readReg(4'd4, rd);
    check(rd == 8'hA5, "R2 io addr high byte", rd, 8'hA5);
    writeReg(4'd7, 8'hFF);
    readReg(4'd7, rd);
    check(rd == 8'h07, "R2 mode readback", rd, 8'h07);
    writeReg(4'd8, 8'h06);
    readReg(4'd8, rd);
    check(rd == 8'h04, "R2 status wp reads 0", rd, 8'h04);

    // R3 write protect
    writeReg(4'd8, 8'h03);
    readReg(4'd8, rd);
    check(rd[0] == 1'b0, "R3 protected set ignored", rd, 8'h00);
    writeReg(4'd8, 8'h01);
    readReg(4'd8, rd);
    check(rd[0] == 1'b1, "R3 unprotected set", rd, 8'h01);
    writeReg(4'd8, 8'h02);
    readReg(4'd8, rd);
    check(rd[0] == 1'b1, "R3 protected clear ignored", rd, 8'h01);
    writeReg(4'd8, 8'h00);
    readReg(4'd8, rd);
    check(rd[0] == 1'b0, "R3 unprotected clear", rd, 8'h00);

    // Table of transfers: R4 R5 R6 R10
    for (int v = 0; v < 4; v++) begin
      logic        dir, dec;
      logic [19:0] m;
      logic [15:0] io;
      logic [7:0]  n;
      {dir, dec, m, io, n} = VECS[v];
      setupChan(dir, dec, 1'b1, m, io, {8'h00, n});
      expMem = m;
      for (int k = 0; k < int'(n); k++) begin
        ioRdData = 8'h3C ^ 8'(k);
        expData = dir ? ioRdData : memModel(expMem);
        runByte(dir, expMem, io, expData);
        expMem = dec ? expMem - 20'd1 : expMem + 20'd1;
        readCount(cnt);
        check(cnt == 16'(int'(n) - k - 1) && ioAddr == io && memAddr == expMem,
              "R5 R10 step after byte", {cnt, memAddr}, {16'(int'(n) - k - 1), expMem});
      end
      readReg(4'd8, rd);
      check(rd == 8'h0C && irq, "R6 termination status", {irq, rd}, {1'b1, 8'h0C});
      writeReg(4'd8, 8'h0C);
      readReg(4'd8, rd);
      check(rd == 8'h04 && !irq, "R6 done cleared", {irq, rd}, {1'b0, 8'h04});
    end

    // R8 level mode: high for 6 cycles gives two bytes
    setupChan(1'b0, 1'b0, 1'b0, 20'h00100, 16'h0010, 16'd5);
    dmaReq = 1'b1;
    repeat (6) @(negedge clk);
    dmaReq = 1'b0;
    @(negedge clk);
    readCount(cnt);
    check(cnt == 16'd3 && memAddr == 20'h00102, "R8 level mode repeats",
          {cnt, memAddr}, {16'd3, 20'h00102});

    // R8 edge mode: held high gives one byte
    writeReg(4'd7, 8'h04);
    dmaReq = 1'b1;
    repeat (8) @(negedge clk);
    dmaReq = 1'b0;
    @(negedge clk);
    readCount(cnt);
    check(cnt == 16'd2, "R8 edge held high one byte", cnt, 16'd2);

    // R9 pending edge during transfer
    dmaReq = 1'b1;
    @(negedge clk);
    dmaReq = 1'b0;
    @(negedge clk);          // write cycle
    dmaReq = 1'b1;
    @(negedge clk);          // idle, pending
    dmaReq = 1'b0;
    @(negedge clk);
    check(memRd, "R9 pending starts read", memRd, 1);
    @(negedge clk);
    @(negedge clk);
    readCount(cnt);
    readReg(4'd8, rd);
    check(cnt == 16'd0 && rd == 8'h0C, "R9 two bytes moved", {cnt, rd}, {16'd0, 8'h0C});

    // R11 requests while disabled
    dmaReq = 1'b1;
    @(negedge clk);
    dmaReq = 1'b0;
    check(!memRd && !ioRd, "R11 no transfer when disabled", {memRd, ioRd}, 0);
    writeReg(4'd5, 8'd2);
    writeReg(4'd8, 8'h0D);
    repeat (4) @(negedge clk);
    readCount(cnt);
    check(cnt == 16'd2, "R11 nothing pending after enable", cnt, 16'd2);

    // R7 count zero means 65536
    setupChan(1'b0, 1'b0, 1'b1, 20'h00200, 16'h0020, 16'd0);
    runByte(1'b0, 20'h00200, 16'h0020, memModel(20'h00200));
    readCount(cnt);
    readReg(4'd8, rd);
    check(cnt == 16'hFFFF && rd[0], "R7 zero count continues", {cnt, rd}, {16'hFFFF, 8'h05});

    // R12 termination coincides with done clear
    setupChan(1'b0, 1'b0, 1'b1, 20'h00300, 16'h0030, 16'd1);
    dmaReq = 1'b1;
    @(negedge clk);
    dmaReq = 1'b0;
    @(negedge clk);          // write cycle
    writeReg(4'd8, 8'h0E);   // lands on terminating edge
    readReg(4'd8, rd);
    check(rd == 8'h0C && irq, "R12 set wins over clear", {irq, rd}, {1'b1, 8'h0C});

    finishRun();
  end

endmodule